// File: doc/BRIEF.md
# Serial Register-Access Slave

This block lets an external serial master read and write a bank of byte-wide registers that sit on an on-chip register bus. The master lowers chip select, clocks in a 16-bit command word (direction flag, burst flag, one spare bit, then a 13-bit register address), and then moves one or more data bytes. Writes go out on the bus as a one-cycle strobe with address and data. Reads issue a one-cycle read strobe. The register bank answers on `reg_rdata` in that same cycle, and the byte is shifted back to the master on MISO.

Three static inputs set the serial format. They choose the idle level of the serial clock, which clock edge samples data, and whether address and data travel least or most significant bit first. The three serial inputs are brought into the system clock domain through two-flop synchronizers, and all edge detection runs on the system clock. The serial clock may run at up to one quarter of the system clock rate. In a burst, the address steps up by one for every byte until chip select rises. A burst read therefore fetches each next byte as soon as the current one has been received, so a burst of N bytes issues N+1 read strobes.

Top module: `spi_regbus_slave`

## Requirements
- R1: While `rst` is high, `spi_miso_oe`, `reg_wr` and `reg_rd` are 0 and `reg_addr` is 0.
- R2: `spi_miso_oe` is 1 exactly when the synchronized chip select is low, two system clocks after `spi_cs_n`. While it is 0, MISO is not driven.
- R3: Command word bit order on the wire: bit 0 is the direction (1 = read), bit 1 is the burst flag, bit 2 is spare and ignored, and bits 3 to 15 carry the address. With `cfg_msb_first` = 0 the address goes least significant bit first, and each data byte goes bit 0 first.
- R4: With `cfg_msb_first` = 1, the address and every data byte travel most significant bit first, while the direction and burst bits stay at wire positions 0 and 1.
- R5: `cfg_cpol` sets the idle level of SCLK. With `cfg_cpha` = 0 MOSI is sampled on the edge leaving idle and MISO changes on the edge returning to idle. With `cfg_cpha` = 1 the roles of the two edges swap. All four combinations work.
- R6: A single write gives exactly one `reg_wr` pulse, one system clock wide, with `reg_addr` equal to the command address and `reg_wdata` equal to the received byte.
- R7: In a burst write, byte k (counting from 0) is written to the command address plus k, modulo 2^13.
- R8: A read pulses `reg_rd` for one clock with the command address after the last address bit is sampled. `reg_wr` and `reg_rd` are never high together. The byte on `reg_rdata` during the `reg_rd` cycle is sent on MISO starting at the next shifting edge.
- R9: In a burst read, after each data byte the address increments and `reg_rd` pulses again, and the next byte is sent without a gap.
- R10: Without the burst flag, only one byte is transferred. Further bytes produce no strobe, and MISO sends 0 for them.
- R11: If chip select rises in the middle of a byte, the partial byte is dropped with no write, and the next transaction decodes normally.
- R12: MISO is 0 during the command word and during write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Idle level of SCLK |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_msb_first | input | 1 | 1: address and data travel MSB first |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for MISO |
| reg_addr | output | 13 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid in the `reg_rd` cycle |

## Verification
Some properties are checked on every cycle. Write strobes are single-cycle. Read and write strobes never overlap. No strobe fires and MISO returns to 0 once chip select is inactive. The address holds steady between byte boundaries. The output enable follows chip select through the synchronizer. Other behaviour can only be shown by the bench scenarios: the command-word decode in each clock mode and bit order, address wrap in a burst, the read-ahead sequence of burst reads, zero fill after a single byte, and recovery after an aborted byte. The bench checks these by comparing each strobe and each received byte against a behavioural model.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

    localparam int ADDR_W   = 13;
    localparam int DATA_W   = 8;
    localparam int CTRL_HDR = 3;
    localparam int CTRL_W   = CTRL_HDR + ADDR_W;

    typedef enum logic [1:0] {
        PH_CTRL,
        PH_DATA,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic sample;
        logic shift;
    } sclk_ev_t;

    // Position within a field of the idx-th bit on the wire
    function automatic int bit_sel(int idx, int width, logic msb_first);
        return msb_first ? (width - 1 - idx) : idx;
    endfunction

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= RST_VAL;
                else     stage[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= RST_VAL;
                else     stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_rb_edge.sv
module spi_rb_edge
    import spi_rb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_act,
    input  logic     sclk_s,
    input  logic     cpol,
    input  logic     cpha,
    output sclk_ev_t ev
);
    logic sclk_prev;
    logic leading, trailing;

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= sclk_s;
    end

    assign leading  = cs_act && (sclk_prev == cpol) && (sclk_s != cpol);
    assign trailing = cs_act && (sclk_prev != cpol) && (sclk_s == cpol);

    always_comb begin
        ev.sample = cpha ? trailing : leading;
        ev.shift  = cpha ? leading  : trailing;
    end

    // R5: an SCLK transition is either a sampling or a shifting edge, never both
    p_edge_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev.sample, ev.shift}))
        else $error("two edge events in one cycle");
endmodule

// File: rtl/spi_rb_core.sv
module spi_rb_core
    import spi_rb_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_act,
    input  sclk_ev_t      ev,
    input  logic          mosi_s,
    input  logic          msb_first,
    input  logic [DW-1:0] reg_rdata,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_wr,
    output logic          reg_rd,
    output logic          miso
);
    localparam int CW    = CTRL_HDR + AW;
    localparam int CNT_W = $clog2(CW);
    localparam int IDX_W = $clog2(DW + 1);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             is_read;
    logic             is_burst;
    logic             first_wr;
    logic [AW-1:0]    addr_acc, addr_next;
    logic [DW-1:0]    data_acc, data_next;
    logic [DW-1:0]    tx_byte;
    logic [IDX_W-1:0] tx_idx;
    logic             tx_bit;

    // Assemble the address with the bit being sampled now
    always_comb begin
        addr_next = addr_acc;
        for (int i = 0; i < AW; i++) begin
            if (int'(cnt) >= CTRL_HDR &&
                i == bit_sel(int'(cnt) - CTRL_HDR, AW, msb_first))
                addr_next[i] = mosi_s;
        end
    end

    always_comb begin
        data_next = data_acc;
        for (int i = 0; i < DW; i++) begin
            if (i == bit_sel(int'(cnt), DW, msb_first))
                data_next[i] = mosi_s;
        end
    end

    always_comb begin
        tx_bit = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (i == bit_sel(int'(tx_idx), DW, msb_first))
                tx_bit = tx_byte[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_addr  <= '0;
            reg_wdata <= '0;
            addr_acc  <= '0;
            data_acc  <= '0;
            tx_byte   <= '0;
            is_read   <= 1'b0;
            is_burst  <= 1'b0;
        end else if (cs_act) begin
            if (ev.sample) begin
                unique case (phase)
                    PH_CTRL: begin
                        if (int'(cnt) == 0) is_read  <= mosi_s;
                        if (int'(cnt) == 1) is_burst <= mosi_s;
                        addr_acc <= addr_next;
                        if (int'(cnt) == CW - 1) reg_addr <= addr_next;
                    end
                    PH_DATA: begin
                        data_acc <= data_next;
                        if (int'(cnt) == DW - 1) begin
                            if (is_read) begin
                                if (is_burst) reg_addr <= reg_addr + AW'(1);
                            end else begin
                                reg_wdata <= data_next;
                                if (!first_wr) reg_addr <= reg_addr + AW'(1);
                            end
                        end
                    end
                    default: ;
                endcase
            end
            if (reg_rd) tx_byte <= reg_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            phase    <= PH_CTRL;
            cnt      <= '0;
            first_wr <= 1'b1;
            tx_idx   <= IDX_W'(DW);
            miso     <= 1'b0;
            reg_wr   <= 1'b0;
            reg_rd   <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (ev.shift) begin
                if (int'(tx_idx) < DW) begin
                    miso   <= tx_bit;
                    tx_idx <= tx_idx + 1'b1;
                end else begin
                    miso <= 1'b0;
                end
            end
            if (reg_rd) tx_idx <= '0;
            if (ev.sample) begin
                unique case (phase)
                    PH_CTRL: begin
                        if (int'(cnt) == CW - 1) begin
                            cnt   <= '0;
                            phase <= PH_DATA;
                            if (is_read) reg_rd <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (int'(cnt) == DW - 1) begin
                            cnt <= '0;
                            if (is_read) begin
                                if (is_burst) reg_rd <= 1'b1;
                                else          phase  <= PH_DONE;
                            end else begin
                                reg_wr   <= 1'b1;
                                first_wr <= 1'b0;
                                if (!is_burst) phase <= PH_DONE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6: every write strobe lasts a single clock
    p_wr_single_r6: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr)
        else $error("write strobe wider than one clock");

    // R8: read and write strobes never coincide
    p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && reg_wr))
        else $error("read and write strobes overlap");

    // R11: no strobe follows an inactive chip select
    p_abort_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (!reg_wr && !reg_rd))
        else $error("strobe after chip select release");

    // R2: MISO returns to 0 once chip select is inactive
    p_miso_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !miso)
        else $error("MISO not cleared");

    // R7: within the data phase the address moves only at a byte boundary
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && !ev.sample) |=> $stable(reg_addr))
        else $error("address changed inside a byte");
endmodule

// File: rtl/spi_regbus_slave.sv
module spi_regbus_slave
    import spi_rb_pkg::*;
#(
    parameter int AW          = ADDR_W,
    parameter int DW          = DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_cpol,
    input  logic          cfg_cpha,
    input  logic          cfg_msb_first,
    input  logic          spi_sclk,
    input  logic          spi_cs_n,
    input  logic          spi_mosi,
    output logic          spi_miso,
    output logic          spi_miso_oe,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_wr,
    output logic          reg_rd,
    input  logic [DW-1:0] reg_rdata
);
    localparam int LN_SCLK = 0;
    localparam int LN_MOSI = 1;
    localparam int LN_CS   = 2;
    localparam int LANES   = 3;

    logic [LANES-1:0] raw, synced;
    logic             cs_act;
    sclk_ev_t         ev;

    assign raw[LN_SCLK] = spi_sclk;
    assign raw[LN_MOSI] = spi_mosi;
    assign raw[LN_CS]   = spi_cs_n;

    spi_rb_sync #(
        .W       (LANES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LANES'(1) << LN_CS)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    assign cs_act      = !synced[LN_CS];
    assign spi_miso_oe = cs_act;

    spi_rb_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .cs_act (cs_act),
        .sclk_s (synced[LN_SCLK]),
        .cpol   (cfg_cpol),
        .cpha   (cfg_cpha),
        .ev     (ev)
    );

    spi_rb_core #(
        .AW (AW),
        .DW (DW)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (cs_act),
        .ev        (ev),
        .mosi_s    (synced[LN_MOSI]),
        .msb_first (cfg_msb_first),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .miso      (spi_miso)
    );

    if (SYNC_STAGES == 2) begin : g_oe_chk
        // R2: the enable only rises after chip select was low at the pin
        p_oe_follows_cs_r2: assert property (@(posedge clk) disable iff (rst)
            spi_miso_oe |-> !$past(spi_cs_n, 2))
            else $error("output enable without chip select");
    end
endmodule

// File: tb/sim_spi_regbus_slave.sv
module sim_spi_regbus_slave;
    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_msb_first = 1'b0;
    logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe;
    logic [12:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        reg_wr, reg_rd;

    always #5 clk = ~clk;

    spi_regbus_slave u0 (
        .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_msb_first(cfg_msb_first), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] bank(logic [12:0] a);
        return a[7:0] ^ {3'b101, a[12:8]};
    endfunction
    assign reg_rdata = bank(reg_addr);

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural model: expected strobes in order, and expected enable
    logic [20:0] exp_wr[$];
    logic [12:0] exp_rd[$];
    logic        h1 = 1'b1, h2 = 1'b1;
    logic [7:0]  wbuf[8];

    always @(posedge clk) begin
        h1 <= spi_cs_n;
        h2 <= h1;
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(spi_miso_oe == !h2, "R2 output enable", spi_miso_oe, !h2);
            if (reg_wr && reg_rd) chk(0, "R8 strobe overlap", 1, 0);
            if (reg_wr) begin
                if (exp_wr.size() == 0) chk(0, "R10 unexpected write", {reg_addr, reg_wdata}, 0);
                else begin
                    logic [20:0] e;
                    e = exp_wr.pop_front();
                    chk({reg_addr, reg_wdata} == e, "R6/R7 write addr+data", {reg_addr, reg_wdata}, e);
                end
            end
            if (reg_rd) begin
                if (exp_rd.size() == 0) chk(0, "R10 unexpected read", reg_addr, 0);
                else begin
                    logic [12:0] e;
                    e = exp_rd.pop_front();
                    chk(reg_addr == e, "R8/R9 read addr", reg_addr, e);
                end
            end
        end
    end

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic set_mode(logic pol, logic pha, logic msb);
        cfg_cpol = pol; cfg_cpha = pha; cfg_msb_first = msb;
        spi_sclk = pol;
        repeat (6) @(negedge clk);
    endtask

    task automatic one_bit(logic b, output logic m);
        if (!cfg_cpha) begin
            spi_mosi = b; half();
            m = spi_miso; spi_sclk = ~cfg_cpol; half();
            spi_sclk = cfg_cpol;
        end else begin
            spi_sclk = ~cfg_cpol; spi_mosi = b; half();
            m = spi_miso; spi_sclk = cfg_cpol; half();
        end
    endtask

    task automatic xfer(logic rd, logic bu, logic rs, logic [12:0] a,
                        int nb, int extra, string tag);
        logic [15:0] cw;
        logic [7:0]  got;
        logic [7:0]  exp;
        logic        m;
        cw[0] = rd; cw[1] = bu; cw[2] = rs;
        for (int k = 0; k < 13; k++) cw[3+k] = cfg_msb_first ? a[12-k] : a[k];
        if (rd) begin
            exp_rd.push_back(a);
            if (bu) for (int i = 1; i <= nb; i++) exp_rd.push_back(13'(a + i));
        end else begin
            for (int i = 0; i < nb; i++)
                if (bu || i == 0) exp_wr.push_back({13'(a + i), wbuf[i]});
        end
        spi_cs_n = 1'b0; half(); half();
        for (int i = 0; i < 16; i++) begin
            one_bit(cw[i], m);
            chk(m == 1'b0, {tag, " R12 MISO during command"}, m, 0);
        end
        for (int i = 0; i < nb; i++) begin
            got = '0;
            for (int j = 0; j < 8; j++) begin
                one_bit(wbuf[i][cfg_msb_first ? 7-j : j], m);
                got[cfg_msb_first ? 7-j : j] = m;
            end
            exp = (rd && (bu || i == 0)) ? bank(13'(a + i)) : 8'h00;
            chk(got == exp, {tag, " R8/R9/R10 MISO byte"}, got, exp);
        end
        for (int j = 0; j < extra; j++) one_bit(1'b1, m);
        half();
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(exp_wr.size() == 0, {tag, " R7/R11 pending writes"}, exp_wr.size(), 0);
        chk(exp_rd.size() == 0, {tag, " R9 pending reads"}, exp_rd.size(), 0);
        exp_wr.delete(); exp_rd.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(spi_miso_oe == 1'b0, "R1 reset enable", spi_miso_oe, 0);
        chk(reg_wr == 1'b0, "R1 reset write strobe", reg_wr, 0);
        chk(reg_rd == 1'b0, "R1 reset read strobe", reg_rd, 0);
        chk(reg_addr == 13'h0, "R1 reset address", reg_addr, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R3 R5 mode 0, LSB first, single write
        set_mode(0, 0, 0);
        wbuf[0] = 8'h3C;
        xfer(0, 0, 0, 13'h0A5, 1, 0, "R3 R6 mode0 write");

        // R8 mode 0 single read
        xfer(1, 0, 0, 13'h123, 1, 0, "R8 mode0 read");

        // R4 R7 mode 3, MSB first, burst write across address wrap
        set_mode(1, 1, 1);
        wbuf[0] = 8'h81; wbuf[1] = 8'h42; wbuf[2] = 8'hE7;
        xfer(0, 1, 0, 13'h1FFE, 3, 0, "R4 R7 mode3 burst write");

        // R9 mode 1, MSB first, burst read
        set_mode(0, 1, 1);
        xfer(1, 1, 0, 13'h0F0, 3, 0, "R9 mode1 burst read");

        // R10 R3 mode 2, LSB first, spare bit set, extra bytes ignored
        set_mode(1, 0, 0);
        wbuf[0] = 8'h5A; wbuf[1] = 8'hFF; wbuf[2] = 8'h11;
        xfer(0, 0, 1, 13'h555, 3, 0, "R10 mode2 single write");
        xfer(1, 0, 0, 13'h0777, 2, 0, "R10 mode2 single read");

        // R11 abort in the middle of the second byte of a burst write
        set_mode(0, 0, 0);
        wbuf[0] = 8'hC3;
        xfer(0, 1, 0, 13'h040, 1, 4, "R11 aborted burst");
        set_mode(0, 1, 0);
        wbuf[0] = 8'h96;
        xfer(0, 0, 0, 13'h1ABC, 1, 0, "R11 after abort mode1 write");
        xfer(1, 1, 0, 13'h0002, 2, 0, "R5 mode1 LSB burst read");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule